// File: doc/BRIEF.md
# Host Register File with Action, Event and Counter Bits

This block is the register file that a host processor sees on a network controller. A small synchronous bus carries a 4-bit register index and 16-bit data. Behind the index sit several kinds of register. Configuration and control registers are written by the host. Status registers mirror levels driven by the datapath. Event registers latch pulses from the datapath and empty when the host reads them. Three 10-bit statistics counters also empty when read.

Four of the host-written registers carry a command bit at bit 6. Writing 1 there produces a one-clock pulse on a dedicated output. The bit is never stored. Each event flag has an enable bit in one of the configuration registers. A single level interrupt is raised while any enabled flag is latched.

The map is as follows. 0 receive-config, 1 transmit-config, 2 buffer-config, 3 self-control and 4 bus-control are read/write. 5 receive events, 6 transmit events and 7 buffer events are flag registers. 8 line status and 9 self status are status registers. 10 missed-frame count, 11 collision count and 12 reflectometer count are the counters. Unused indices read 0. A read returns its data on `host_rdata` in the clock cycle after the read is presented. Outside a read cycle the output is 0.

Top module: `nic_hostregs`

## Requirements
- R1: Each counter (index 10 on `miss_inc`, 11 on `coll_inc`, 12 on `tdr_inc`) adds one per clock with its strobe high. A read of the counter returns its value in bits [9:0] with the upper bits 0, and leaves the counter at 0.
- R2: A counter at 1023 stays at 1023 on further strobes, and does not wrap.
- R3: A strobe in the same cycle as a read of that counter makes the read return the old value. The counter is left at 1.
- R4: A write with bit 6 set to index 0, 3, 4 or 2 drives `act_rx_skip`, `act_self_reset`, `act_dma_reset` or `act_soft_int` respectively. The pulse is high for exactly the one clock after the write. A write with bit 6 clear gives no pulse.
- R5: Bit 6 of indices 0, 2, 3 and 4 always reads 0. Every other bit of indices 0 to 4 reads back as last written.
- R6: Index 8 reads `line_stat` and index 9 reads `self_stat`. Host writes to indices 5 to 12 change nothing.
- R7: An event input bit k (`rx_evt`, `tx_evt`, `buf_evt` for indices 5, 6, 7) sets flag bit k+8 of its register. The flag holds until that register is read. The read returns the flags and clears them.
- R8: An event arriving in the same cycle as the read of its register is not lost. The flag is set after the read.
- R9: In the buffer event register, `buf_tmp_clr[1]` clears flag bit 15 and `buf_tmp_clr[0]` clears flag bit 11 without a host read.
- R10: `irq` is high while some latched flag at bit n of index 5, 6 or 7 has bit n set in index 0, 1 or 2 respectively. `irq` falls once all such flags are cleared.
- R11: After reset all registers, counters and flags are 0, `irq` and every action output are low, and `host_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_idx | input | 4 | Register index |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid the cycle after a read |
| rx_evt | input | 8 | Receive event pulses |
| tx_evt | input | 8 | Transmit event pulses |
| buf_evt | input | 8 | Buffer event pulses |
| buf_tmp_clr | input | 2 | Hardware clears for buffer flags 15 and 11 |
| line_stat | input | 16 | Line status levels |
| self_stat | input | 16 | Self status levels |
| miss_inc | input | 1 | Missed-frame count strobe |
| coll_inc | input | 1 | Collision count strobe |
| tdr_inc | input | 1 | Reflectometer count strobe |
| cfg_rx | output | 16 | Receive-config contents |
| cfg_tx | output | 16 | Transmit-config contents |
| cfg_buf | output | 16 | Buffer-config contents |
| ctl_self | output | 16 | Self-control contents |
| ctl_bus | output | 16 | Bus-control contents |
| act_rx_skip | output | 1 | Receive skip action pulse |
| act_self_reset | output | 1 | Self reset action pulse |
| act_dma_reset | output | 1 | Receive DMA reset action pulse |
| act_soft_int | output | 1 | Software interrupt action pulse |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the index and strobes are known in every clock after reset. They also assume that a hardware clear on a buffer flag never coincides with a new event on that same bit, because the set-over-clear rule is only checked for host reads. The stimulus changes inputs only on the falling edge. It keeps `buf_tmp_clr` low whenever `buf_evt` is pulsed. It presents at most one read or one write per cycle, so every read result in the scoreboard queue maps to exactly one request.

// File: rtl/nic_hostregs_pkg.sv
package nic_hostregs_pkg;
    localparam int IDXW = 4;
    localparam int IDX_RCFG  = 0;
    localparam int IDX_TCFG  = 1;
    localparam int IDX_BCFG  = 2;
    localparam int IDX_SCTL  = 3;
    localparam int IDX_BCTL  = 4;
    localparam int IDX_RXEV  = 5;
    localparam int IDX_TXEV  = 6;
    localparam int IDX_BFEV  = 7;
    localparam int IDX_LST   = 8;
    localparam int IDX_SST   = 9;
    localparam int IDX_CTR0  = 10;
    localparam int NCTR      = 3;
    localparam int NCFG      = 5;
    localparam int NACT      = 4;
    localparam int ACT_BIT   = 6;
    localparam int BIT_RXDEST = 15;
    localparam int BIT_RX128  = 11;
endpackage

// File: rtl/nic_sat_ctr.sv
module nic_sat_ctr #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = inc_i ? CW'(1) : '0;
        end else if (inc_i && st_q.cnt != MAXV) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R2
    ctr_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == MAXV && !clr_i) |=> (st_q.cnt == MAXV));

    // R3
    ctr_clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && inc_i) |=> (st_q.cnt == CW'(1)));
endmodule

// File: rtl/nic_evt_latch.sv
module nic_evt_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         rd_clr_i,
    input  logic [W-1:0] hw_clr_i,
    output logic [W-1:0] flag_o
);
    typedef struct packed {
        logic [W-1:0] flag;
    } evl_t;

    evl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < W; k++) begin
            if (evt_i[k])                      st_d.flag[k] = 1'b1;
            else if (rd_clr_i || hw_clr_i[k])  st_d.flag[k] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R8
    evt_survive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && (evt_i != '0)) |=> ((st_q.flag & $past(evt_i)) == $past(evt_i)));

    // R7
    evt_cor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && evt_i == '0) |=> (st_q.flag == '0));
endmodule

// File: rtl/nic_hostregs.sv
module nic_hostregs
    import nic_hostregs_pkg::*;
#(
    parameter int DW  = 16,
    parameter int EVW = 8,
    parameter int CW  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr,
    input  logic            host_rd,
    input  logic [IDXW-1:0] host_idx,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    input  logic [EVW-1:0]  rx_evt,
    input  logic [EVW-1:0]  tx_evt,
    input  logic [EVW-1:0]  buf_evt,
    input  logic [1:0]      buf_tmp_clr,
    input  logic [DW-1:0]   line_stat,
    input  logic [DW-1:0]   self_stat,
    input  logic            miss_inc,
    input  logic            coll_inc,
    input  logic            tdr_inc,
    output logic [DW-1:0]   cfg_rx,
    output logic [DW-1:0]   cfg_tx,
    output logic [DW-1:0]   cfg_buf,
    output logic [DW-1:0]   ctl_self,
    output logic [DW-1:0]   ctl_bus,
    output logic            act_rx_skip,
    output logic            act_self_reset,
    output logic            act_dma_reset,
    output logic            act_soft_int,
    output logic            irq
);
    localparam int EV_LSB = DW - EVW;
    localparam logic [DW-1:0] ACT_MASK = DW'(1) << ACT_BIT;
    localparam int NEVG = 3;

    // which configuration slots carry an action bit, and which action slot
    localparam logic [NCFG-1:0] HAS_ACT = 5'b11101;
    localparam int ACT_SLOT [NCFG] = '{0, 0, 3, 1, 2};

    typedef struct packed {
        logic [NCFG-1:0][DW-1:0] cfg;
        logic [NACT-1:0]         act;
        logic [DW-1:0]           rdata;
    } regs_t;

    regs_t st_d, st_q;

    logic [NCTR-1:0]           ctr_inc;
    logic [NCTR-1:0]           ctr_clr;
    logic [NCTR-1:0][CW-1:0]   ctr_val;
    logic [NEVG-1:0][EVW-1:0]  ev_in;
    logic [NEVG-1:0][EVW-1:0]  ev_hwclr;
    logic [NEVG-1:0]           ev_clr;
    logic [NEVG-1:0][EVW-1:0]  ev_flag;
    logic [NEVG-1:0][EVW-1:0]  ev_en;

    assign ctr_inc = {tdr_inc, coll_inc, miss_inc};
    assign ev_in   = {buf_evt, tx_evt, rx_evt};

    always_comb begin
        ev_hwclr = '0;
        ev_hwclr[2][BIT_RXDEST-EV_LSB] = buf_tmp_clr[1];
        ev_hwclr[2][BIT_RX128-EV_LSB]  = buf_tmp_clr[0];
    end

    // statistics counters
    for (genvar c = 0; c < NCTR; c++) begin : g_ctr
        assign ctr_clr[c] = host_rd && (host_idx == IDXW'(IDX_CTR0 + c));
        nic_sat_ctr #(.CW(CW)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (ctr_inc[c]),
            .clr_i (ctr_clr[c]),
            .cnt_o (ctr_val[c])
        );
    end

    // event flag groups, each enabled by the matching config slot
    for (genvar g = 0; g < NEVG; g++) begin : g_evt
        assign ev_clr[g] = host_rd && (host_idx == IDXW'(IDX_RXEV + g));
        assign ev_en[g]  = st_q.cfg[IDX_RCFG + g][DW-1:EV_LSB];
        nic_evt_latch #(.W(EVW)) u_evl (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (ev_in[g]),
            .rd_clr_i (ev_clr[g]),
            .hw_clr_i (ev_hwclr[g]),
            .flag_o   (ev_flag[g])
        );
    end

    always_comb begin
        logic [DW-1:0] rmux;
        st_d     = st_q;
        st_d.act = '0;
        for (int r = 0; r < NCFG; r++) begin
            if (host_wr && host_idx == IDXW'(r)) begin
                if (HAS_ACT[r]) begin
                    st_d.cfg[r] = host_wdata & ~ACT_MASK;
                    st_d.act[ACT_SLOT[r]] = host_wdata[ACT_BIT];
                end else begin
                    st_d.cfg[r] = host_wdata;
                end
            end
        end
        rmux = '0;
        if (int'(host_idx) < NCFG) begin
            rmux = st_q.cfg[host_idx[2:0]];
        end else if (int'(host_idx) < IDX_LST) begin
            for (int g = 0; g < NEVG; g++) begin
                if (host_idx == IDXW'(IDX_RXEV + g)) rmux = {ev_flag[g], {EV_LSB{1'b0}}};
            end
        end else if (host_idx == IDXW'(IDX_LST)) begin
            rmux = line_stat;
        end else if (host_idx == IDXW'(IDX_SST)) begin
            rmux = self_stat;
        end else begin
            for (int c = 0; c < NCTR; c++) begin
                if (host_idx == IDXW'(IDX_CTR0 + c)) rmux = {{(DW-CW){1'b0}}, ctr_val[c]};
            end
        end
        st_d.rdata = host_rd ? rmux : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        irq = 1'b0;
        for (int g = 0; g < NEVG; g++) irq = irq | (|(ev_flag[g] & ev_en[g]));
    end

    assign host_rdata     = st_q.rdata;
    assign cfg_rx         = st_q.cfg[IDX_RCFG];
    assign cfg_tx         = st_q.cfg[IDX_TCFG];
    assign cfg_buf        = st_q.cfg[IDX_BCFG];
    assign ctl_self       = st_q.cfg[IDX_SCTL];
    assign ctl_bus        = st_q.cfg[IDX_BCTL];
    assign act_rx_skip    = st_q.act[0];
    assign act_self_reset = st_q.act[1];
    assign act_dma_reset  = st_q.act[2];
    assign act_soft_int   = st_q.act[3];

    // R4
    act_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_idx == IDXW'(IDX_RCFG) && host_wdata[ACT_BIT]) |=> act_rx_skip);

    // R4
    act_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_idx == IDXW'(IDX_SCTL) && host_wdata[ACT_BIT]) |=> !act_self_reset);

    // R5
    act_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_idx == IDXW'(IDX_BCTL)) |=> !host_rdata[ACT_BIT]);

    // R6
    stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_idx == IDXW'(IDX_LST)) |=> (host_rdata == $past(line_stat)));
endmodule

// File: tb/nic_hostregs_bench.sv
module nic_hostregs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 0, host_rd = 0;
    logic [3:0]  host_idx = 0;
    logic [15:0] host_wdata = 0;
    logic [15:0] host_rdata;
    logic [7:0]  rx_evt = 0, tx_evt = 0, buf_evt = 0;
    logic [1:0]  buf_tmp_clr = 0;
    logic [15:0] line_stat = 0, self_stat = 0;
    logic        miss_inc = 0, coll_inc = 0, tdr_inc = 0;
    logic [15:0] cfg_rx, cfg_tx, cfg_buf, ctl_self, ctl_bus;
    logic        act_rx_skip, act_self_reset, act_dma_reset, act_soft_int, irq;

    int nchk = 0, nfail = 0;
    logic rd_seen = 1'b0;

    typedef struct { logic [15:0] exp; string tag; } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;

    nic_hostregs u_nic_hostregs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_evt(rx_evt), .tx_evt(tx_evt), .buf_evt(buf_evt), .buf_tmp_clr(buf_tmp_clr),
        .line_stat(line_stat), .self_stat(self_stat),
        .miss_inc(miss_inc), .coll_inc(coll_inc), .tdr_inc(tdr_inc),
        .cfg_rx(cfg_rx), .cfg_tx(cfg_tx), .cfg_buf(cfg_buf),
        .ctl_self(ctl_self), .ctl_bus(ctl_bus),
        .act_rx_skip(act_rx_skip), .act_self_reset(act_self_reset),
        .act_dma_reset(act_dma_reset), .act_soft_int(act_soft_int), .irq(irq)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per completed read
    always @(posedge clk) rd_seen <= host_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sbq.size() == 0) begin
                nchk++; nfail++;
                $display("FAIL scoreboard empty actual=%h expected=none", host_rdata);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(host_rdata, e.exp, e.tag);
            end
        end
    end

    task automatic rd(input logic [3:0] idx, input logic [15:0] exp, input string tag);
        exp_t e;
        e.exp = exp; e.tag = tag;
        sbq.push_back(e);
        host_idx = idx; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [15:0] d);
        host_idx = idx; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20ns * 200000);
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk({15'd0, irq}, 16'd0, "R11 irq");
        chk({12'd0, act_rx_skip, act_self_reset, act_dma_reset, act_soft_int}, 16'd0, "R11 actions");
        chk(host_rdata, 16'd0, "R11 rdata");
        rd(4'd0, 16'h0000, "R11 rcfg");
        rd(4'd10, 16'h0000, "R11 miss counter");

        // R4 / R5 action bits
        wr(4'd0, 16'hFFFF);
        chk({15'd0, act_rx_skip}, 16'd1, "R4 rx skip pulse");
        @(negedge clk);
        chk({15'd0, act_rx_skip}, 16'd0, "R4 rx skip one cycle");
        rd(4'd0, 16'hFFBF, "R5 rcfg readback");
        wr(4'd3, 16'h0000);
        chk({15'd0, act_self_reset}, 16'd0, "R4 no pulse on zero");
        wr(4'd3, 16'h1240);
        chk({15'd0, act_self_reset}, 16'd1, "R4 self reset pulse");
        wr(4'd4, 16'h0041);
        chk({15'd0, act_dma_reset}, 16'd1, "R4 dma reset pulse");
        wr(4'd2, 16'h8840);
        chk({15'd0, act_soft_int}, 16'd1, "R4 soft int pulse");
        rd(4'd3, 16'h1200, "R5 sctl readback");
        rd(4'd4, 16'h0001, "R5 bctl readback");
        rd(4'd2, 16'h8800, "R5 bcfg readback");
        wr(4'd1, 16'h00C0);
        rd(4'd1, 16'h00C0, "R5 tcfg keeps bit 6");

        // R6 status and read-only registers
        line_stat = 16'hA5C3; self_stat = 16'h0F0F;
        rd(4'd8, 16'hA5C3, "R6 line status");
        wr(4'd8, 16'h1234);
        rd(4'd8, 16'hA5C3, "R6 status write ignored");
        rd(4'd9, 16'h0F0F, "R6 self status");
        wr(4'd5, 16'hFFFF);
        rd(4'd5, 16'h0000, "R6 event write ignored");
        wr(4'd10, 16'h03FF);
        rd(4'd10, 16'h0000, "R6 counter write ignored");

        // R1 counting and clear on read
        for (int i = 0; i < 5; i++) begin miss_inc = 1; @(negedge clk); miss_inc = 0; @(negedge clk); end
        rd(4'd10, 16'd5, "R1 miss count");
        rd(4'd10, 16'd0, "R1 miss cleared");
        for (int i = 0; i < 3; i++) begin coll_inc = 1; @(negedge clk); end
        coll_inc = 0;
        rd(4'd11, 16'd3, "R1 coll count");
        tdr_inc = 1; @(negedge clk); tdr_inc = 0;
        rd(4'd12, 16'd1, "R1 tdr count");
        rd(4'd12, 16'd0, "R1 tdr cleared");

        // R2 saturation
        miss_inc = 1; idle(1030); miss_inc = 0;
        rd(4'd10, 16'd1023, "R2 saturated");
        rd(4'd10, 16'd0, "R2 cleared after saturation");

        // R3 strobe coincident with clearing read
        coll_inc = 1; idle(2);
        rd(4'd11, 16'd2, "R3 old value on read");
        coll_inc = 0;
        rd(4'd11, 16'd1, "R3 strobe kept");

        // R7 / R10 event latch and interrupt
        rx_evt = 8'h02; @(negedge clk); rx_evt = 8'h00;
        idle(2);
        chk({15'd0, irq}, 16'd1, "R10 irq on enabled event");
        rd(4'd5, 16'h0200, "R7 rx flag");
        chk({15'd0, irq}, 16'd0, "R10 irq drops after read");
        rd(4'd5, 16'h0000, "R7 rx flag cleared");
        tx_evt = 8'h01; @(negedge clk); tx_evt = 8'h00;
        chk({15'd0, irq}, 16'd0, "R10 disabled event no irq");
        rd(4'd6, 16'h0100, "R7 tx flag latched");

        // R8 coincident event and read
        rx_evt = 8'h01; @(negedge clk);
        rd(4'd5, 16'h0100, "R8 read during event");
        rx_evt = 8'h00;
        rd(4'd5, 16'h0100, "R8 event survived");

        // R9 hardware clear of buffer flags
        buf_evt = 8'h88; @(negedge clk); buf_evt = 8'h00;
        buf_tmp_clr = 2'b10; @(negedge clk); buf_tmp_clr = 2'b00;
        chk({15'd0, irq}, 16'd1, "R10 irq from remaining buffer flag");
        rd(4'd7, 16'h0800, "R9 bit 15 cleared by hardware");
        chk({15'd0, irq}, 16'd0, "R10 irq clear after buffer read");
        buf_evt = 8'h08; @(negedge clk); buf_evt = 8'h00;
        buf_tmp_clr = 2'b01; @(negedge clk); buf_tmp_clr = 2'b00;
        rd(4'd7, 16'h0000, "R9 bit 11 cleared by hardware");

        idle(3);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule